// File: doc/BRIEF.md
# Flash Page Rewrite Sequencer

This block sits behind the serial command front end of a paged flash device. It collects a 32-bit command frame one bit at a time while chip select is low. The bits arrive already recovered into the core clock domain. When chip select returns high after a complete frame that carries one of the two rewrite opcodes, the block starts a two-step array operation. The first step copies the addressed main-memory page into one of the two page buffers. The second step programs that same buffer back into the same page. Each step is handed to the array controller through a request/done handshake.

The block also keeps the single array-lock of the device. While a rewrite, or an array operation owned by another command decoder, is in progress, new array work is refused. Buffer-only work that other decoders ask for is always granted. A hardware protect input shields the lowest pages from any rewrite. A refused command leaves the array untouched and sets an error flag that stays high until reset.

Top module: `page_rewrite_seq`

## Requirements
- R1: In a frame received most significant bit first, opcode byte 0x58 selects buffer 0 (`arr_buf`=0) and 0x59 selects buffer 1 (`arr_buf`=1). The page number is frame bits 18..9. Bits 23..19 and 8..0 have no effect.
- R2: A rewrite starts only at the clock edge that first samples `cs_n` high after at least 32 bits were taken with `cs_n` low. From that edge `arr_req`=1, `arr_phase`=0, and `arr_page`/`arr_buf` carry the decoded values.
- R3: If `cs_n` rises after fewer than 32 bits, nothing happens: `arr_req`, `busy` and `err` keep their values.
- R4: A clock edge that samples `arr_done` high in phase 0 moves `arr_phase` to 1 with the same page and buffer. The edge that samples `arr_done` high in phase 1 drops `arr_req`.
- R5: `busy` is high from the launch edge until the edge that samples the second `arr_done`, and also whenever `oth_busy` is high. `arr_req` never stands without `busy`.
- R6: A complete rewrite frame that arrives while `busy` is high does not start and sets `err`.
- R7: With `wp_n` low, a rewrite of a page below 256 is refused: `arr_req` stays 0 and `err` is set. With `wp_n` high, or for page 256 and up, the rewrite runs.
- R8: An `oth_req` pulse with `oth_is_array`=0 gets `oth_grant` one edge later, even when busy. With `oth_is_array`=1 it gets `oth_grant` when not busy, or `oth_reject` and `err` when busy.
- R9: `err` stays 1 until reset, whatever follows.
- R10: After reset, `arr_req`, `busy` (with `oth_busy` low), `err`, `oth_grant` and `oth_reject` are 0.
- R11: A complete frame with any other opcode byte starts nothing and does not set `err`.
- R12: If a rewrite launches in the same cycle as an array `oth_req`, the rewrite wins and the other request gets `oth_reject`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Chip select, active low, core domain |
| bit_vld | input | 1 | One command bit present this cycle |
| bit_dat | input | 1 | Command bit value |
| wp_n | input | 1 | Low-page protect, active low |
| arr_req | output | 1 | Array step request |
| arr_phase | output | 1 | 0 = page to buffer copy, 1 = buffer to page program |
| arr_buf | output | 1 | Buffer selected for the rewrite |
| arr_page | output | 10 | Page being rewritten |
| arr_done | input | 1 | Array step finished (pulse) |
| oth_req | input | 1 | Request pulse from another command decoder |
| oth_is_array | input | 1 | That request needs the array |
| oth_busy | input | 1 | Another decoder's array operation is running |
| oth_grant | output | 1 | Request accepted (pulse) |
| oth_reject | output | 1 | Request refused (pulse) |
| busy | output | 1 | Device busy with array work |
| err | output | 1 | Sticky rejected-command flag |

## Verification
Launch, refusal and error results are registered at the first edge that sees `cs_n` high. Phase steps land on the edge that samples `arr_done`, and grants or rejections follow one edge after `oth_req`. The `busy` term from `oth_busy` is combinational and due in the same cycle. The bench drives every input on the falling clock edge and samples on the next falling edge, so exactly one rising edge lies between each stimulus and its check. Longer sequences are stepped one such edge at a time.

// File: rtl/rw_pkg.sv
package rw_pkg;

  localparam logic [7:0] OPC_RW_BUF0 = 8'h58;
  localparam logic [7:0] OPC_RW_BUF1 = 8'h59;
  localparam int unsigned OPC_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_PROG = 2'd2
  } rw_state_t;

  typedef enum logic {
    PH_COPY = 1'b0,
    PH_PROG = 1'b1
  } rw_phase_t;

endpackage

// File: rtl/rw_frame_rx.sv
module rw_frame_rx #(
  parameter int unsigned FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               bit_vld,
  input  logic               bit_dat,
  output logic [FRAME_W-1:0] frame,
  output logic               frame_full,
  output logic               cs_rise
);

  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               cs_q;
  logic               shift_en;

  // accept bits only while selected and until the frame is full
  assign shift_en = !cs_n && bit_vld && (cnt_q != CNT_FULL);

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (cs_n) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sr_d  = {sr_q[FRAME_W-2:0], bit_dat};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      cs_q  <= 1'b1;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      cs_q  <= cs_n;
    end
  end

  assign frame      = sr_q;
  assign frame_full = (cnt_q == CNT_FULL);
  assign cs_rise    = cs_n && !cs_q;

  // R3: bit count never passes a full frame
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

endmodule

// File: rtl/rw_cmd_decode.sv
module rw_cmd_decode
  import rw_pkg::*;
#(
  parameter int unsigned PAGE_W     = 10,
  parameter int unsigned RSVD_W     = 5,
  parameter int unsigned DC_W       = 9,
  parameter int unsigned PROT_PAGES = 256,
  localparam int unsigned FRAME_W   = OPC_W + RSVD_W + PAGE_W + DC_W
) (
  input  logic [FRAME_W-1:0] frame,
  input  logic               frame_full,
  input  logic               cs_rise,
  input  logic               wp_n,
  output logic               cmd_hit,
  output logic               cmd_buf,
  output logic [PAGE_W-1:0]  cmd_page,
  output logic               cmd_wp_block
);

  localparam int unsigned OPC_LSB  = FRAME_W - OPC_W;
  localparam int unsigned PAGE_LSB = DC_W;
  localparam logic [PAGE_W:0] PROT_LIM = (PAGE_W+1)'(PROT_PAGES);

  logic [OPC_W-1:0] opc;
  logic             opc_match;

  assign opc      = frame[OPC_LSB +: OPC_W];
  assign cmd_page = frame[PAGE_LSB +: PAGE_W];

  always_comb begin
    opc_match = 1'b0;
    cmd_buf   = 1'b0;
    unique case (opc)
      OPC_RW_BUF0: opc_match = 1'b1;
      OPC_RW_BUF1: begin
        opc_match = 1'b1;
        cmd_buf   = 1'b1;
      end
      default: ;
    endcase
  end

  assign cmd_hit      = cs_rise && frame_full && opc_match;
  assign cmd_wp_block = !wp_n && ({1'b0, cmd_page} < PROT_LIM);

endmodule

// File: rtl/rw_arbiter.sv
module rw_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_hit,
  input  logic cmd_wp_block,
  input  logic rw_active,
  input  logic oth_busy,
  input  logic oth_req,
  input  logic oth_is_array,
  output logic launch,
  output logic busy,
  output logic oth_grant,
  output logic oth_reject,
  output logic err
);

  logic grant_q, grant_d;
  logic rej_q, rej_d;
  logic err_q, err_d;
  logic cmd_refused;

  assign busy        = rw_active || oth_busy;
  assign launch      = cmd_hit && !busy && !cmd_wp_block;
  assign cmd_refused = cmd_hit && (busy || cmd_wp_block);

  always_comb begin
    grant_d = 1'b0;
    rej_d   = 1'b0;
    if (oth_req) begin
      if (!oth_is_array) begin
        grant_d = 1'b1;
      end else if (busy || launch) begin
        rej_d = 1'b1;
      end else begin
        grant_d = 1'b1;
      end
    end
    err_d = err_q || cmd_refused || rej_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      rej_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      grant_q <= grant_d;
      rej_q   <= rej_d;
      err_q   <= err_d;
    end
  end

  assign oth_grant  = grant_q;
  assign oth_reject = rej_q;
  assign err        = err_q;

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_grant_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(oth_grant && oth_reject));
  p_buf_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oth_req && !oth_is_array |=> oth_grant);
  p_reject_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oth_reject |-> err);

endmodule

// File: rtl/rw_phase_fsm.sv
module rw_phase_fsm
  import rw_pkg::*;
#(
  parameter int unsigned PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              cmd_buf,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic              arr_done,
  output logic              arr_req,
  output logic              arr_phase,
  output logic              arr_buf,
  output logic [PAGE_W-1:0] arr_page,
  output logic              rw_active
);

  rw_state_t         st_q, st_d;
  logic [PAGE_W-1:0] page_q;
  logic              buf_q;
  logic              ld_en;

  assign ld_en = launch && (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (launch)   st_d = ST_COPY;
      ST_COPY: if (arr_done) st_d = ST_PROG;
      ST_PROG: if (arr_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      buf_q  <= 1'b0;
    end else if (ld_en) begin
      page_q <= cmd_page;
      buf_q  <= cmd_buf;
    end
  end

  assign arr_req   = (st_q != ST_IDLE);
  assign arr_phase = (st_q == ST_PROG) ? PH_PROG : PH_COPY;
  assign arr_buf   = buf_q;
  assign arr_page  = page_q;
  assign rw_active = arr_req;

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_done |=> arr_req && $stable(arr_phase) && $stable(arr_page) && $stable(arr_buf));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && arr_done && (arr_phase == PH_COPY) |=> arr_req && (arr_phase == PH_PROG));
  p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && arr_done && (arr_phase == PH_PROG) |=> !arr_req);
  p_start_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_req) |-> (arr_phase == PH_COPY));

endmodule

// File: rtl/page_rewrite_seq.sv
module page_rewrite_seq
  import rw_pkg::*;
#(
  parameter int unsigned PAGE_W     = 10,
  parameter int unsigned RSVD_W     = 5,
  parameter int unsigned DC_W       = 9,
  parameter int unsigned PROT_PAGES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              bit_vld,
  input  logic              bit_dat,
  input  logic              wp_n,
  output logic              arr_req,
  output logic              arr_phase,
  output logic              arr_buf,
  output logic [PAGE_W-1:0] arr_page,
  input  logic              arr_done,
  input  logic              oth_req,
  input  logic              oth_is_array,
  input  logic              oth_busy,
  output logic              oth_grant,
  output logic              oth_reject,
  output logic              busy,
  output logic              err
);

  localparam int unsigned FRAME_W = OPC_W + RSVD_W + PAGE_W + DC_W;

  logic [1:0]         rst_sync_q;
  logic               rst_core_n;
  logic [FRAME_W-1:0] frame;
  logic               frame_full;
  logic               cs_rise;
  logic               cmd_hit;
  logic               cmd_buf;
  logic [PAGE_W-1:0]  cmd_page;
  logic               cmd_wp_block;
  logic               launch;
  logic               rw_active;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  rw_frame_rx #(.FRAME_W(FRAME_W)) rx_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cs_n       (cs_n),
    .bit_vld    (bit_vld),
    .bit_dat    (bit_dat),
    .frame      (frame),
    .frame_full (frame_full),
    .cs_rise    (cs_rise)
  );

  rw_cmd_decode #(
    .PAGE_W     (PAGE_W),
    .RSVD_W     (RSVD_W),
    .DC_W       (DC_W),
    .PROT_PAGES (PROT_PAGES)
  ) dec_i (
    .frame        (frame),
    .frame_full   (frame_full),
    .cs_rise      (cs_rise),
    .wp_n         (wp_n),
    .cmd_hit      (cmd_hit),
    .cmd_buf      (cmd_buf),
    .cmd_page     (cmd_page),
    .cmd_wp_block (cmd_wp_block)
  );

  rw_arbiter arb_i (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .cmd_hit      (cmd_hit),
    .cmd_wp_block (cmd_wp_block),
    .rw_active    (rw_active),
    .oth_busy     (oth_busy),
    .oth_req      (oth_req),
    .oth_is_array (oth_is_array),
    .launch       (launch),
    .busy         (busy),
    .oth_grant    (oth_grant),
    .oth_reject   (oth_reject),
    .err          (err)
  );

  rw_phase_fsm #(.PAGE_W(PAGE_W)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .launch    (launch),
    .cmd_buf   (cmd_buf),
    .cmd_page  (cmd_page),
    .arr_done  (arr_done),
    .arr_req   (arr_req),
    .arr_phase (arr_phase),
    .arr_buf   (arr_buf),
    .arr_page  (arr_page),
    .rw_active (rw_active)
  );

  p_req_busy_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    arr_req |-> busy);
  p_wp_guard_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(arr_req) |-> $past(wp_n) || ({1'b0, arr_page} >= (PAGE_W+1)'(PROT_PAGES)));
  p_other_busy_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    oth_busy |-> busy);

endmodule

// File: tb/page_rewrite_seq_tb_top.sv
`timescale 1ns/1ps
module page_rewrite_seq_tb_top;

  typedef struct packed {
    logic [7:0] opc;
    logic [9:0] page;
    logic       wp;
    logic [5:0] nbits;
    logic       go;
    logic       er;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'h58, 10'd300,  1'b1, 6'd32, 1'b1, 1'b0},
    '{8'h59, 10'd5,    1'b1, 6'd32, 1'b1, 1'b0},
    '{8'h58, 10'd5,    1'b0, 6'd32, 1'b0, 1'b1},
    '{8'h59, 10'd255,  1'b0, 6'd32, 1'b0, 1'b1},
    '{8'h58, 10'd256,  1'b0, 6'd32, 1'b1, 1'b0},
    '{8'h58, 10'd1023, 1'b1, 6'd31, 1'b0, 1'b0},
    '{8'h57, 10'd10,   1'b1, 6'd32, 1'b0, 1'b0},
    '{8'h59, 10'd0,    1'b1, 6'd8,  1'b0, 1'b0},
    '{8'h59, 10'd1023, 1'b0, 6'd32, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n, cs_n, bit_vld, bit_dat, wp_n;
  logic arr_req, arr_phase, arr_buf, arr_done;
  logic [9:0] arr_page;
  logic oth_req, oth_is_array, oth_busy, oth_grant, oth_reject, busy, err;
  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  page_rewrite_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
    .wp_n(wp_n), .arr_req(arr_req), .arr_phase(arr_phase), .arr_buf(arr_buf),
    .arr_page(arr_page), .arr_done(arr_done), .oth_req(oth_req),
    .oth_is_array(oth_is_array), .oth_busy(oth_busy), .oth_grant(oth_grant),
    .oth_reject(oth_reject), .busy(busy), .err(err)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; bit_vld = 1'b0; bit_dat = 1'b0; wp_n = 1'b1;
    arr_done = 1'b0; oth_req = 1'b0; oth_is_array = 1'b0; oth_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // sends nbits of the frame; the last negedge raises cs_n (optionally with oth_req)
  task automatic send_frame(input logic [7:0] opc, input logic [9:0] page,
                            input int nbits, input bit with_oth);
    logic [31:0] fr;
    fr = {opc, 5'h15, page, 9'h1AB};
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      bit_vld = 1'b1;
      bit_dat = fr[31-i];
      @(negedge clk);
    end
    bit_vld = 1'b0;
    cs_n = 1'b1;
    if (with_oth) begin
      oth_req = 1'b1;
      oth_is_array = 1'b1;
    end
    @(negedge clk);
    oth_req = 1'b0;
  endtask

  task automatic pulse_done();
    arr_done = 1'b1;
    @(negedge clk);
    arr_done = 1'b0;
  endtask

  task automatic other_req(input bit is_arr);
    oth_req = 1'b1;
    oth_is_array = is_arr;
    @(negedge clk);
    oth_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    check("R10 arr_req", arr_req, 0);
    check("R10 busy", busy, 0);
    check("R10 err", err, 0);
    check("R10 grant", oth_grant, 0);
    check("R10 reject", oth_reject, 0);

    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      wp_n = VECS[v].wp;
      send_frame(VECS[v].opc, VECS[v].page, int'(VECS[v].nbits), 1'b0);
      check($sformatf("R2/R3/R7/R11 v%0d arr_req", v), arr_req, VECS[v].go);
      check($sformatf("R5 v%0d busy", v), busy, VECS[v].go);
      check($sformatf("R6/R7 v%0d err", v), err, VECS[v].er);
      if (VECS[v].go) begin
        check($sformatf("R1 v%0d page", v), arr_page, VECS[v].page);
        check($sformatf("R1 v%0d buf", v), arr_buf, VECS[v].opc[0]);
        check($sformatf("R2 v%0d phase", v), arr_phase, 0);
        repeat (2) @(negedge clk);
        check($sformatf("R4 v%0d hold phase", v), arr_phase, 0);
        pulse_done();
        check($sformatf("R4 v%0d phase1", v), arr_phase, 1);
        check($sformatf("R4 v%0d req", v), arr_req, 1);
        check($sformatf("R4 v%0d page1", v), arr_page, VECS[v].page);
        check($sformatf("R5 v%0d busy1", v), busy, 1);
        pulse_done();
        check($sformatf("R4 v%0d end req", v), arr_req, 0);
        check($sformatf("R5 v%0d end busy", v), busy, 0);
      end
    end

    // R6: rewrite frame during own rewrite
    do_reset();
    send_frame(8'h58, 10'd700, 32, 1'b0);
    send_frame(8'h59, 10'd12, 32, 1'b0);
    check("R6 err", err, 1);
    check("R6 page kept", arr_page, 700);
    check("R6 buf kept", arr_buf, 0);
    check("R6 phase kept", arr_phase, 0);
    // R8: buffer-only granted while busy, array rejected
    other_req(1'b0);
    check("R8 buf grant busy", oth_grant, 1);
    check("R8 buf no reject", oth_reject, 0);
    other_req(1'b1);
    check("R8 arr reject busy", oth_reject, 1);
    check("R8 arr no grant", oth_grant, 0);
    pulse_done();
    pulse_done();
    check("R9 err after finish", err, 1);
    repeat (5) @(negedge clk);
    check("R9 err sticky", err, 1);

    // R6 with other decoder busy
    do_reset();
    oth_busy = 1'b1;
    @(negedge clk);
    check("R5 oth busy", busy, 1);
    send_frame(8'h58, 10'd400, 32, 1'b0);
    check("R6 oth busy no req", arr_req, 0);
    check("R6 oth busy err", err, 1);
    oth_busy = 1'b0;
    @(negedge clk);
    check("R5 oth busy clear", busy, 0);

    // R8 array grant when idle
    do_reset();
    other_req(1'b1);
    check("R8 arr grant idle", oth_grant, 1);
    check("R8 idle no err", err, 0);
    @(negedge clk);
    check("R8 grant pulse", oth_grant, 0);

    // R12 simultaneous launch and array request
    do_reset();
    send_frame(8'h59, 10'd900, 32, 1'b1);
    check("R12 rewrite wins", arr_req, 1);
    check("R12 other rejected", oth_reject, 1);
    check("R12 no grant", oth_grant, 0);
    check("R12 page", arr_page, 900);

    // R3 short frame during busy: no change to err
    send_frame(8'h58, 10'd3, 20, 1'b0);
    check("R3 short busy err", err, 1);
    check("R3 short page", arr_page, 900);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule